// File: doc/BRIEF.md
# GPIO Interrupt Cause and Summary Unit

This unit turns a bank of up to 32 polarity-corrected input levels into grouped interrupt requests for one, two or four processors. Each pin can raise an interrupt in two ways. On the level path the present input value, gated by a level enable bit, is the request. On the edge path a rising transition of the input sets a sticky cause bit, which is gated by an edge enable bit. For each pin the two paths are ORed. The requests of every eight consecutive pins are then ORed into one summary line.

Every processor has its own pair of enable registers and therefore its own set of summary lines. In the four-processor build each processor also has a private cause register. All of these copies latch the same edges, but each one is cleared on its own. Software clears cause bits by writing zeros. A one in the written word leaves that bit alone, so one handler can acknowledge its own pins without disturbing pins that other handlers own.

Register access is a single-cycle write port and a combinational read port. Address map, in bytes: with one or two processors the shared cause register is at 0x14, processor 0 edge enable is at 0x18 and level enable at 0x1C, and processor 1 edge enable is at 0x30 and level enable at 0x34. With four processors, processor c has its cause register at 0x40+4c, edge enable at 0x50+4c and level enable at 0x60+4c.

Top module: `gpio_irq_cause`

## Requirements
- R1: After reset every cause bit and every enable bit is zero, and every summary line is low.
- R2: A 0-to-1 change of pin_level[i] sets cause bit i, and the bit reads back as set from the cycle after the clock edge that sampled the change. A falling input, or an input held steady, sets nothing.
- R3: A write to a cause register clears each bit written as 0 and keeps each bit written as 1.
- R4: When a rising input and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R5: Level path: pin i requests while pin_level[i] and that processor's level enable bit i are both 1. The request follows the input in the same cycle and drops as soon as the input falls.
- R6: Edge path: pin i requests while cause bit i and that processor's edge enable bit i are both 1. The request stays after the input falls, until the cause bit is cleared.
- R7: irq_out[c*G+g], with G=ceil(N_PINS/8), is the OR of the requests of pins 8g to 8g+7 for processor c.
- R8: With two processors, the enable registers at 0x18/0x1C (processor 0) and 0x30/0x34 (processor 1) are separate. An enable bit set for one processor never raises the other processor's lines.
- R9: With four processors, each processor has a private cause register at 0x40+4c that all edges set, and clearing one copy leaves the other copies unchanged.
- R10: Every register reads back its value at its own address, with no wait cycle. Unmapped addresses read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | N_PINS | Polarity-corrected input levels |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | AW | Write byte address |
| reg_wdata | input | DW | Write data |
| reg_raddr | input | AW | Read byte address |
| reg_rdata | output | DW | Read data, combinational |
| irq_out | output | N_CPUS*ceil(N_PINS/8) | Summary lines, processor-major |

## Verification
Two events can fall on the same cause bit in one cycle: an input rising edge that sets the bit, and a software write of zero that clears it. The bench produces this by raising an input in the same cycle as a cause write of all zeros. It then reads the register back the next cycle and expects the new bit to survive while the older bits are gone. It also clears a bit in the same cycle as a falling input, and clears a bit while its input stays high, and checks in both cases that no edge is seen.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int MAXW = 32;
  localparam int MAXG = 4;

  // byte address of the cause register visible to processor cpu
  function automatic logic [7:0] cause_addr(input int ncpu, input int cpu);
    return (ncpu == 4) ? 8'(8'h40 + cpu * 4) : 8'h14;
  endfunction

  function automatic logic [7:0] edge_en_addr(input int ncpu, input int cpu);
    if (ncpu == 4) return 8'(8'h50 + cpu * 4);
    return (cpu == 0) ? 8'h18 : 8'h30;
  endfunction

  function automatic logic [7:0] lvl_en_addr(input int ncpu, input int cpu);
    if (ncpu == 4) return 8'(8'h60 + cpu * 4);
    return (cpu == 0) ? 8'h1C : 8'h34;
  endfunction

  // per-pin request: level path OR edge path
  function automatic logic [MAXW-1:0] pin_request(input logic [MAXW-1:0] lvl_in,
                                                  input logic [MAXW-1:0] lvl_en,
                                                  input logic [MAXW-1:0] cause,
                                                  input logic [MAXW-1:0] edge_en);
    return (lvl_in & lvl_en) | (cause & edge_en);
  endfunction

  // OR reduce each byte lane of requests into one line
  function automatic logic [MAXG-1:0] lane_any(input logic [MAXW-1:0] req);
    logic [MAXG-1:0] r;
    for (int g = 0; g < MAXG; g++) r[g] = |req[g*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/gpio_irq_edge_latch.sv
module gpio_irq_edge_latch #(
  parameter int N_PINS  = 32,
  parameter int N_CAUSE = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_PINS-1:0]               lvl_in,
  input  logic [N_CAUSE-1:0]              clr_hit,
  input  logic [N_PINS-1:0]               clr_data,
  output logic [N_PINS-1:0]               rise,
  output logic [N_CAUSE-1:0][N_PINS-1:0]  cause
);

  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_in;
  end

  assign rise = lvl_in & ~prev_q;

  for (genvar k = 0; k < N_CAUSE; k++) begin : g_copy
    logic [N_PINS-1:0] keep;
    assign keep = clr_hit[k] ? clr_data : '1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause[k] <= '0;
      else        cause[k] <= (cause[k] & keep) | rise;
    end

    // R2: a bit only becomes set where a rise was seen
    a_r2_set_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause[k] & ~$past(cause[k]) & ~$past(rise)) == '0));
    // R3: bits written as one are kept
    a_r3_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[k] |=> (($past(cause[k]) & $past(clr_data) & ~cause[k]) == '0));
    // R3: bits written as zero are cleared unless a rise coincides
    a_r3_zeros_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[k] |=> ((cause[k] & ~$past(clr_data) & ~$past(rise)) == '0));
    // R4: a rise always lands, even against a clearing write
    a_r4_rise_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause[k] & $past(rise)) == $past(rise)));
  end

endmodule

// File: rtl/gpio_irq_mask_regs.sv
module gpio_irq_mask_regs #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_edge,
  input  logic              we_lvl,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] edge_en,
  output logic [N_PINS-1:0] lvl_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_en <= '0;
      lvl_en  <= '0;
    end else begin
      if (we_edge) edge_en <= wdata;
      if (we_lvl)  lvl_en  <= wdata;
    end
  end

  // R10: a write changes only the register it addresses
  a_r10_edge_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we_edge |=> $stable(edge_en));
  a_r10_lvl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we_lvl |=> $stable(lvl_en));

endmodule

// File: rtl/gpio_irq_group_or.sv
module gpio_irq_group_or
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS   = 32,
  parameter int N_GROUPS = 4
) (
  input  logic [N_PINS-1:0]   req,
  output logic [N_GROUPS-1:0] grp
);

  logic [MAXG-1:0] all_lanes;
  assign all_lanes = lane_any(MAXW'(req));
  assign grp       = all_lanes[N_GROUPS-1:0];

endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int N_CPUS = 2,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_PINS-1:0]            pin_level,
  input  logic                         reg_we,
  input  logic [AW-1:0]                reg_waddr,
  input  logic [DW-1:0]                reg_wdata,
  input  logic [AW-1:0]                reg_raddr,
  output logic [DW-1:0]                reg_rdata,
  output logic [N_CPUS*((N_PINS+7)/8)-1:0] irq_out
);

  localparam int N_GROUPS = (N_PINS + 7) / 8;
  localparam int N_CAUSE  = (N_CPUS == 4) ? 4 : 1;

  logic [N_PINS-1:0]               wpins;
  logic [N_CAUSE-1:0]              clr_hit;
  logic [N_PINS-1:0]               rise;
  logic [N_CAUSE-1:0][N_PINS-1:0]  cause;
  logic [N_CPUS-1:0][N_PINS-1:0]   edge_en;
  logic [N_CPUS-1:0][N_PINS-1:0]   lvl_en;
  logic [N_CPUS-1:0][N_PINS-1:0]   req;

  assign wpins = reg_wdata[N_PINS-1:0];

  for (genvar k = 0; k < N_CAUSE; k++) begin : g_clr
    assign clr_hit[k] = reg_we && (reg_waddr == AW'(cause_addr(N_CPUS, k)));
  end

  gpio_irq_edge_latch #(.N_PINS(N_PINS), .N_CAUSE(N_CAUSE)) u_latch (
    .clk(clk), .rst_n(rst_n), .lvl_in(pin_level), .clr_hit(clr_hit),
    .clr_data(wpins), .rise(rise), .cause(cause)
  );

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    localparam int CI = (N_CAUSE == 1) ? 0 : c;
    logic we_e, we_l;
    logic [MAXW-1:0] req_w;
    logic [N_GROUPS-1:0] lines;

    assign we_e = reg_we && (reg_waddr == AW'(edge_en_addr(N_CPUS, c)));
    assign we_l = reg_we && (reg_waddr == AW'(lvl_en_addr(N_CPUS, c)));

    gpio_irq_mask_regs #(.N_PINS(N_PINS)) u_masks (
      .clk(clk), .rst_n(rst_n), .we_edge(we_e), .we_lvl(we_l),
      .wdata(wpins), .edge_en(edge_en[c]), .lvl_en(lvl_en[c])
    );

    assign req_w  = pin_request(MAXW'(pin_level), MAXW'(lvl_en[c]),
                                MAXW'(cause[CI]), MAXW'(edge_en[c]));
    assign req[c] = req_w[N_PINS-1:0];

    gpio_irq_group_or #(.N_PINS(N_PINS), .N_GROUPS(N_GROUPS)) u_grp (
      .req(req[c]), .grp(lines)
    );
    assign irq_out[c*N_GROUPS +: N_GROUPS] = lines;

    // R5: an enabled high level always reaches this processor's lines
    a_r5_level_reaches: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_level & lvl_en[c]) != '0) |-> (lines != '0));
    // R8: a processor with no enables set stays quiet
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((lvl_en[c] == '0) && (edge_en[c] == '0)) |-> (lines == '0));
    // R6: an enabled pending cause keeps the lines up
    a_r6_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause[CI] & edge_en[c]) != '0) |-> (lines != '0));
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < N_CAUSE; k++)
      if (reg_raddr == AW'(cause_addr(N_CPUS, k))) reg_rdata = DW'(cause[k]);
    for (int c = 0; c < N_CPUS; c++) begin
      if (reg_raddr == AW'(edge_en_addr(N_CPUS, c))) reg_rdata = DW'(edge_en[c]);
      if (reg_raddr == AW'(lvl_en_addr(N_CPUS, c)))  reg_rdata = DW'(lvl_en[c]);
    end
  end

endmodule

// File: tb/gpio_irq_cause_test.sv
module gpio_irq_cause_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_level = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] rdata2, rdata4;
  logic [7:0]  irq2;
  logic [15:0] irq4;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_cause #(.N_PINS(32), .N_CPUS(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(rdata2), .irq_out(irq2)
  );

  gpio_irq_cause #(.N_PINS(32), .N_CPUS(4)) uut4 (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(rdata4), .irq_out(irq4)
  );

  typedef enum logic [1:0] {OBS_IRQ2, OBS_RD2, OBS_IRQ4, OBS_RD4} obs_e;
  typedef struct {
    obs_e        what;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int fails = 0;
  bit done = 0;

  // scoreboard monitor: results are compared away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.what)
        OBS_IRQ2: act = 32'(irq2);
        OBS_RD2:  act = rdata2;
        OBS_IRQ4: act = 32'(irq4);
        default:  act = rdata4;
      endcase
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s %s: actual %h expected %h", it.tag, it.what.name(), act, it.exp);
      end
    end
  end

  task automatic step(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                      input logic [31:0] din, input logic [7:0] ra);
    @(posedge clk);
    #1;
    reg_we = we; reg_waddr = wa; reg_wdata = wd; pin_level = din; reg_raddr = ra;
  endtask

  task automatic expect_item(input obs_e w, input logic [31:0] e, input string t);
    item_t it;
    it.what = w; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    step(0, 8'h00, 0, 0, 8'h14);
    expect_item(OBS_IRQ2, 0, "R1"); expect_item(OBS_RD2, 0, "R1"); expect_item(OBS_IRQ4, 0, "R1");
    step(1, 8'h1C, 32'h0000_0101, 0, 8'h1C);
    step(0, 8'h00, 0, 0, 8'h1C);
    expect_item(OBS_RD2, 32'h0000_0101, "R10");
    step(1, 8'h30, 32'hFF00_0000, 32'h1, 8'h14);
    expect_item(OBS_IRQ2, 32'h01, "R5");
    step(0, 8'h00, 0, 32'h100, 8'h14);
    expect_item(OBS_IRQ2, 32'h02, "R7"); expect_item(OBS_RD2, 32'h1, "R2");
    step(0, 8'h00, 0, 0, 8'h14);
    expect_item(OBS_IRQ2, 0, "R5"); expect_item(OBS_RD2, 32'h101, "R2");
    step(0, 8'h00, 0, 32'h8000_0000, 8'h30);
    expect_item(OBS_IRQ2, 0, "R6"); expect_item(OBS_RD2, 32'hFF00_0000, "R8");
    step(0, 8'h00, 0, 0, 8'h14);
    expect_item(OBS_IRQ2, 32'h80, "R6"); expect_item(OBS_RD2, 32'h8000_0101, "R2");
    step(1, 8'h14, 32'h7FFF_FFFF, 0, 8'h14);
    expect_item(OBS_IRQ2, 32'h80, "R6");
    step(0, 8'h00, 0, 0, 8'h14);
    expect_item(OBS_IRQ2, 0, "R3"); expect_item(OBS_RD2, 32'h101, "R3");
    // rise and clearing write in the same cycle
    step(1, 8'h14, 32'h0, 32'h8000_0000, 8'h14);
    step(0, 8'h00, 0, 32'h8000_0000, 8'h14);
    expect_item(OBS_RD2, 32'h8000_0000, "R4"); expect_item(OBS_IRQ2, 32'h80, "R4");
    // clear while the input falls
    step(1, 8'h14, 32'h0, 0, 8'h14);
    step(0, 8'h00, 0, 0, 8'h14);
    expect_item(OBS_RD2, 0, "R2"); expect_item(OBS_IRQ2, 0, "R3");
    // clear while the input stays high
    step(0, 8'h00, 0, 32'h1, 8'h14);
    expect_item(OBS_IRQ2, 32'h01, "R5");
    step(1, 8'h14, 32'h0, 32'h1, 8'h14);
    expect_item(OBS_RD2, 32'h1, "R2");
    step(0, 8'h00, 0, 32'h1, 8'h14);
    expect_item(OBS_RD2, 0, "R2"); expect_item(OBS_IRQ2, 32'h01, "R5");
    step(1, 8'h20, 32'hFFFF_FFFF, 0, 8'h20);
    step(0, 8'h00, 0, 0, 8'h20);
    expect_item(OBS_RD2, 0, "R10");
    // second processor level enable
    step(1, 8'h34, 32'h0001_0000, 0, 8'h34);
    step(0, 8'h00, 0, 32'h0001_0000, 8'h34);
    expect_item(OBS_RD2, 32'h0001_0000, "R8"); expect_item(OBS_IRQ2, 32'h40, "R8");
    step(0, 8'h00, 0, 0, 8'h14);
    expect_item(OBS_IRQ2, 0, "R8"); expect_item(OBS_RD2, 32'h0001_0000, "R2");
    // four-processor build
    step(1, 8'h58, 32'h1, 0, 8'h48);
    expect_item(OBS_IRQ4, 0, "R9");
    step(1, 8'h48, 32'h0, 0, 8'h4C);
    expect_item(OBS_RD4, 32'h8001_0101, "R9"); expect_item(OBS_IRQ4, 32'h100, "R9");
    step(0, 8'h00, 0, 0, 8'h4C);
    expect_item(OBS_IRQ4, 0, "R9"); expect_item(OBS_RD4, 32'h8001_0101, "R9");
    step(0, 8'h00, 0, 32'h1, 8'h48);
    expect_item(OBS_IRQ4, 0, "R9");
    step(0, 8'h00, 0, 0, 8'h58);
    expect_item(OBS_IRQ4, 32'h100, "R9"); expect_item(OBS_RD4, 32'h1, "R10");

    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule